// File: doc/BRIEF.md
# Banked Program Counter and Next-Address Sequencer

This block owns the 13-bit program counter of a small 4-bit controller. Every cycle it picks the next fetch address from the requests it receives: reset, a pending interrupt, a return, a decoded branch or call, or a plain step past the current instruction. Decode logic supplies the instruction class, its operand field, its byte length and the status flag. Stack storage sits outside the block. The block reports when a return address must be pushed and supplies that address. Popped addresses come back on a data input.

The 13-bit code space is split into two 4K windows. The lower window is always physical bank 0. The upper window goes to one of three physical banks, chosen by a 2-bit select register that the block holds. The resulting 14-bit ROM address is driven combinationally from the counter and the select register.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the counter and the bank-select register are cleared, so `pc_o`, `bank_o` and `rom_addr_o` read 0 after that edge, and `push_o` and `restore_o` stay low during reset.
- R2: `rom_addr_o[11:0]` equals `pc_o[11:0]`. `rom_addr_o[13:12]` is 0 when `pc_o[12]` is 0. When `pc_o[12]` is 1 it is 1 for select code 00 or 11, 2 for code 01 and 3 for code 10.
- R3: When `bank_we_i` is high at a rising edge (outside reset), `bank_d_i` is stored and shows on `bank_o` and in the address map from the next cycle on, whatever the flow request in that cycle.
- R4: Sequential step (`op_i`=0, or the unused codes 6 and 7) advances the counter by `len_i` (1, 2 or 3), modulo 2^13.
- R5: Short branch (`op_i`=1). With `sf_i`=1 the counter takes bits 12..6 of PC+1 and `arg_i[5:0]` in bits 5..0. With `sf_i`=0 it becomes PC+1.
- R6: Long branch (`op_i`=2). With `sf_i`=1 the counter keeps its bit 12 and loads `arg_i[11:0]`. With `sf_i`=0 it becomes PC+2.
- R7: Full branch (`op_i`=3). With `sf_i`=1 the counter loads `arg_i[12:0]`. With `sf_i`=0 it becomes PC+3.
- R8: Short call (`op_i`=4) with n=`arg_i[3:0]` jumps to 8n+6 for n=1..15 and to 086h for n=0. In the same cycle it asserts `push_o` with `push_pc_o`=PC+1.
- R9: Long call (`op_i`=5) loads `arg_i[10:0]` with bits 12..11 cleared. In the same cycle it asserts `push_o` with `push_pc_o`=PC+2.
- R10: Any set bit of `irq_i` is accepted at once, and the lowest set index wins. It asserts `push_o` with `push_pc_o` equal to the current `pc_o`. The counter then loads the vector 2*(index+1): bit 0 gives 002h, bit 1 004h, bit 2 006h, bit 3 008h, bit 4 00Ah, bit 5 00Ch.
- R11: `ret_i` or `rti_i` loads the counter from `ret_data_i`. `rti_i` also raises `restore_o` for that single cycle.
- R12: Priority is reset, then interrupt, then return, then branch/call, then sequential step. A request that loses is dropped and raises no push or restore for that cycle.
- R13: With no interrupt, no return and `op_valid_i` low, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | A decoded instruction completes this cycle |
| op_i | input | 3 | Instruction class: 0 step, 1 short branch, 2 long branch, 3 full branch, 4 short call, 5 long call |
| arg_i | input | 13 | Operand field carrying the target or call index |
| len_i | input | 2 | Instruction length in bytes for a sequential step |
| sf_i | input | 1 | Status flag gating the branches |
| irq_i | input | 6 | Interrupt requests, bit 0 highest priority |
| ret_i | input | 1 | Return from subroutine |
| rti_i | input | 1 | Return from interrupt |
| ret_data_i | input | 13 | Address popped from the external stack |
| bank_we_i | input | 1 | Write strobe for the bank-select register |
| bank_d_i | input | 2 | New bank-select code |
| pc_o | output | 13 | Current program counter |
| rom_addr_o | output | 14 | Physical ROM fetch address |
| bank_o | output | 2 | Current bank-select code |
| push_o | output | 1 | Push request to the stack this cycle |
| push_pc_o | output | 13 | Address to push |
| restore_o | output | 1 | Restore-flags strobe for a return from interrupt |

## Verification
The bound checker checks on every cycle the properties that hold structurally. It checks the address split and the bank range of the upper window. It checks that a sequential step advances by exactly the given length, and that an accepted interrupt pushes the current counter and lands on an even vector below 00Eh. It also checks that a return loads the popped data, that the restore strobe only appears with an unpreempted return from interrupt, and that call targets fall in their fixed ranges. Only the bench scenarios can show the exact values. These include the 086h special case of the short call and the per-source vector order when several interrupts collide. They also include the kept upper bits on taken branches, the equal mapping of select codes 00 and 11, and the dropping of losing requests when reset, interrupt, return and call arrive together.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W    = 13;
    localparam int OFS_W   = 12;
    localparam int SEL_W   = 2;
    localparam int ROM_AW  = OFS_W + SEL_W;
    localparam int LEN_W   = 2;
    localparam int OP_W    = 3;
    localparam int IRQ_N   = 6;
    localparam int IRQ_IW  = $clog2(IRQ_N + 1);
    localparam int SBR_W   = 6;
    localparam int LCALL_W = 11;
    localparam int SCALL_W = 4;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [OP_W-1:0] {
        OP_STEP  = 3'd0,
        OP_SBR   = 3'd1,
        OP_LBR   = 3'd2,
        OP_FBR   = 3'd3,
        OP_SCALL = 3'd4,
        OP_LCALL = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        SRC_RESET,
        SRC_IRQ,
        SRC_RETURN,
        SRC_INSN,
        SRC_HOLD
    } src_e;

    // Result of evaluating one decoded instruction
    typedef struct packed {
        pc_t  target;
        logic push;
        pc_t  link;
    } flow_t;

    // Short call destination: 8n+6, with index 0 redirected
    function automatic pc_t scall_target(input logic [SCALL_W-1:0] n);
        pc_t t;
        if (n == '0)
            t = PC_W'(13'h086);
        else
            t = PC_W'({n, 3'b110});
        return t;
    endfunction

    // Physical bank for the upper code window
    function automatic sel_t upper_bank(input sel_t code);
        sel_t b;
        case (code)
            2'b01:   b = 2'd2;
            2'b10:   b = 2'd3;
            default: b = 2'd1;
        endcase
        return b;
    endfunction

    // Interrupt vector for a winning source index
    function automatic pc_t irq_vector(input logic [IRQ_IW-1:0] idx);
        logic [IRQ_IW-1:0] k;
        k = idx + IRQ_IW'(1);
        return PC_W'({k, 1'b0});
    endfunction

endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
(
    input  pc_t              pc,
    input  logic [OP_W-1:0]  op,
    input  pc_t              arg,
    input  logic [LEN_W-1:0] len,
    input  logic             sf,
    output flow_t            flow
);

    pc_t pc_p1, pc_p2, pc_p3, pc_pl;
    op_e kind;

    always_comb begin
        pc_p1 = pc + PC_W'(1);
        pc_p2 = pc + PC_W'(2);
        pc_p3 = pc + PC_W'(3);
        pc_pl = pc + PC_W'(len);
        kind  = op_e'(op);
    end

    always_comb begin
        flow.target = pc_pl;
        flow.push   = 1'b0;
        flow.link   = pc_p1;
        case (kind)
            OP_SBR: begin
                if (sf)
                    flow.target = {pc_p1[PC_W-1:SBR_W], arg[SBR_W-1:0]};
                else
                    flow.target = pc_p1;
            end
            OP_LBR: begin
                if (sf)
                    flow.target = {pc[PC_W-1:OFS_W], arg[OFS_W-1:0]};
                else
                    flow.target = pc_p2;
            end
            OP_FBR: begin
                if (sf)
                    flow.target = arg;
                else
                    flow.target = pc_p3;
            end
            OP_SCALL: begin
                flow.target = scall_target(arg[SCALL_W-1:0]);
                flow.push   = 1'b1;
                flow.link   = pc_p1;
            end
            OP_LCALL: begin
                flow.target = {{(PC_W-LCALL_W){1'b0}}, arg[LCALL_W-1:0]};
                flow.push   = 1'b1;
                flow.link   = pc_p2;
            end
            default: flow.target = pc_pl;
        endcase
    end

endmodule

// File: rtl/pcseq_arb.sv
module pcseq_arb
    import pcseq_pkg::*;
(
    input  logic             rst,
    input  pc_t              pc,
    input  logic [IRQ_N-1:0] irq,
    input  logic             ret,
    input  logic             rti,
    input  pc_t              ret_data,
    input  logic             op_valid,
    input  flow_t            flow,
    output src_e             src,
    output pc_t              next_pc,
    output logic             push,
    output pc_t              push_pc,
    output logic             restore
);

    logic              irq_hit;
    logic [IRQ_IW-1:0] irq_idx;

    // Lowest set index wins: scan downward so it is assigned last
    always_comb begin
        irq_hit = 1'b0;
        irq_idx = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (irq[i]) begin
                irq_hit = 1'b1;
                irq_idx = IRQ_IW'(i);
            end
        end
    end

    always_comb begin
        if (rst)
            src = SRC_RESET;
        else if (irq_hit)
            src = SRC_IRQ;
        else if (ret || rti)
            src = SRC_RETURN;
        else if (op_valid)
            src = SRC_INSN;
        else
            src = SRC_HOLD;
    end

    always_comb begin
        next_pc = pc;
        push    = 1'b0;
        push_pc = pc;
        restore = 1'b0;
        case (src)
            SRC_RESET:  next_pc = '0;
            SRC_IRQ: begin
                next_pc = irq_vector(irq_idx);
                push    = 1'b1;
                push_pc = pc;
            end
            SRC_RETURN: begin
                next_pc = ret_data;
                restore = rti;
            end
            SRC_INSN: begin
                next_pc = flow.target;
                push    = flow.push;
                push_pc = flow.link;
            end
            default:    next_pc = pc;
        endcase
    end

endmodule

// File: rtl/pcseq_bankmap.sv
module pcseq_bankmap
    import pcseq_pkg::*;
(
    input  pc_t               pc,
    input  sel_t              sel,
    output logic [ROM_AW-1:0] rom_addr
);

    sel_t phys;

    always_comb begin
        if (pc[PC_W-1])
            phys = upper_bank(sel);
        else
            phys = '0;
        rom_addr = {phys, pc[OFS_W-1:0]};
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic [2:0]        op_i,
    input  logic [12:0]       arg_i,
    input  logic [1:0]        len_i,
    input  logic              sf_i,
    input  logic [5:0]        irq_i,
    input  logic              ret_i,
    input  logic              rti_i,
    input  logic [12:0]       ret_data_i,
    input  logic              bank_we_i,
    input  logic [1:0]        bank_d_i,
    output logic [12:0]       pc_o,
    output logic [13:0]       rom_addr_o,
    output logic [1:0]        bank_o,
    output logic              push_o,
    output logic [12:0]       push_pc_o,
    output logic              restore_o
);

    pc_t   pc_q;
    sel_t  sel_q;
    flow_t flow;
    src_e  src;
    pc_t   next_pc;

    pcseq_target u_target (
        .pc   (pc_q),
        .op   (op_i),
        .arg  (arg_i),
        .len  (len_i),
        .sf   (sf_i),
        .flow (flow)
    );

    pcseq_arb u_arb (
        .rst      (rst),
        .pc       (pc_q),
        .irq      (irq_i),
        .ret      (ret_i),
        .rti      (rti_i),
        .ret_data (ret_data_i),
        .op_valid (op_valid_i),
        .flow     (flow),
        .src      (src),
        .next_pc  (next_pc),
        .push     (push_o),
        .push_pc  (push_pc_o),
        .restore  (restore_o)
    );

    pcseq_bankmap u_map (
        .pc       (pc_q),
        .sel      (sel_q),
        .rom_addr (rom_addr_o)
    );

    always_ff @(posedge clk) begin
        if (src == SRC_RESET) begin
            pc_q  <= '0;
            sel_q <= '0;
        end else begin
            pc_q <= next_pc;
            if (bank_we_i)
                sel_q <= bank_d_i;
        end
    end

    assign pc_o   = pc_q;
    assign bank_o = sel_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid_i,
    input logic [2:0]  op_i,
    input logic [1:0]  len_i,
    input logic [5:0]  irq_i,
    input logic        ret_i,
    input logic        rti_i,
    input logic [12:0] ret_data_i,
    input logic [12:0] pc_o,
    input logic [13:0] rom_addr_o,
    input logic [1:0]  bank_o,
    input logic        push_o,
    input logic [12:0] push_pc_o,
    input logic        restore_o
);

    logic rst_q = 1'b0;
    logic quiet;

    always_ff @(posedge clk) rst_q <= rst;

    assign quiet = (irq_i == 6'd0) && !ret_i && !rti_i && op_valid_i;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_STATE: assert (pc_o == 13'd0 && bank_o == 2'd0) else $error("reset state"); // R1
        end
    end

    AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !pc_o[12] |-> rom_addr_o[13:12] == 2'd0) else $error("low window"); // R2

    AST_HIGH_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pc_o[12] |-> rom_addr_o[13:12] != 2'd0) else $error("high window"); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        rom_addr_o[11:0] == pc_o[11:0]) else $error("offset"); // R2

    AST_STEP_LEN: assert property (@(posedge clk) disable iff (rst)
        (quiet && op_i == 3'd0) |=> pc_o == $past(pc_o) + 13'($past(len_i))) else $error("step"); // R4

    AST_SCALL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (quiet && op_i == 3'd4) |=> (pc_o[2:0] == 3'b110 && pc_o[12:8] == 5'd0)) else $error("scall"); // R8

    AST_LCALL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (quiet && op_i == 3'd5) |=> pc_o[12:11] == 2'd0) else $error("lcall"); // R9

    AST_IRQ_PUSH: assert property (@(posedge clk) disable iff (rst)
        (irq_i != 6'd0) |-> (push_o && push_pc_o == pc_o)) else $error("irq push"); // R10

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (irq_i != 6'd0) |=> (pc_o[0] == 1'b0 && pc_o[12:4] == 9'd0 && pc_o[3:1] != 3'd0 && pc_o[3:1] != 3'd7))
        else $error("irq vector"); // R10

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
        ((ret_i || rti_i) && irq_i == 6'd0) |=> pc_o == $past(ret_data_i)) else $error("return"); // R11

    AST_RESTORE_SRC: assert property (@(posedge clk) disable iff (rst)
        restore_o |-> (rti_i && irq_i == 6'd0)) else $error("restore"); // R12

endmodule

bind pcseq_top pcseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .len_i      (len_i),
    .irq_i      (irq_i),
    .ret_i      (ret_i),
    .rti_i      (rti_i),
    .ret_data_i (ret_data_i),
    .pc_o       (pc_o),
    .rom_addr_o (rom_addr_o),
    .bank_o     (bank_o),
    .push_o     (push_o),
    .push_pc_o  (push_pc_o),
    .restore_o  (restore_o)
);

// File: tb/sim_pcseq_top.sv
`timescale 1ns/1ps
module sim_pcseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [12:0] arg_i = 13'd0;
    logic [1:0]  len_i = 2'd1;
    logic        sf_i = 1'b0;
    logic [5:0]  irq_i = 6'd0;
    logic        ret_i = 1'b0;
    logic        rti_i = 1'b0;
    logic [12:0] ret_data_i = 13'd0;
    logic        bank_we_i = 1'b0;
    logic [1:0]  bank_d_i = 2'd0;
    logic [12:0] pc_o;
    logic [13:0] rom_addr_o;
    logic [1:0]  bank_o;
    logic        push_o;
    logic [12:0] push_pc_o;
    logic        restore_o;

    pcseq_top u0 (.*);

    always #2.5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int m_pc = 0;
    int m_bank = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rom(int pc, int bank);
        int phys;
        if (pc < 4096) return pc;
        phys = (bank == 1) ? 2 : (bank == 2) ? 3 : 1;
        return phys * 4096 + pc % 4096;
    endfunction

    // One cycle: check same-cycle outputs, clock, update model, check state
    task automatic tick(string tag);
        int np, nb, ep, epp, er, a, n;
        #1;
        np = m_pc; nb = m_bank; ep = 0; epp = 0; er = 0;
        a = int'(arg_i);
        if (rst) begin
            np = 0; nb = 0;
        end else begin
            if (bank_we_i) nb = int'(bank_d_i);
            if (irq_i != 0) begin
                for (int i = 5; i >= 0; i--) if (irq_i[i]) np = 2 * (i + 1);
                ep = 1; epp = m_pc;
            end else if (ret_i || rti_i) begin
                np = int'(ret_data_i); er = rti_i ? 1 : 0;
            end else if (op_valid_i) begin
                case (op_i)
                    3'd1: np = sf_i ? ((m_pc + 1) / 64) * 64 + a % 64 : m_pc + 1;
                    3'd2: np = sf_i ? (m_pc / 4096) * 4096 + a % 4096 : m_pc + 2;
                    3'd3: np = sf_i ? a : m_pc + 3;
                    3'd4: begin
                        n = a % 16;
                        np = (n == 0) ? 134 : 8 * n + 6;
                        ep = 1; epp = (m_pc + 1) % 8192;
                    end
                    3'd5: begin
                        np = a % 2048; ep = 1; epp = (m_pc + 2) % 8192;
                    end
                    default: np = m_pc + int'(len_i);
                endcase
            end
        end
        np = np % 8192;
        chk(tag, "push", int'(push_o), ep);
        if (ep == 1) chk(tag, "push_pc", int'(push_pc_o), epp);
        chk(tag, "restore", int'(restore_o), er);
        @(posedge clk);
        m_pc = np; m_bank = nb;
        #0.5;
        chk(tag, "pc", int'(pc_o), m_pc);
        chk(tag, "rom_addr", int'(rom_addr_o), exp_rom(m_pc, m_bank));
        chk(tag, "bank", int'(bank_o), m_bank);
    endtask

    task automatic idle();
        op_valid_i = 0; irq_i = 0; ret_i = 0; rti_i = 0; bank_we_i = 0; rst = 0;
    endtask

    task automatic insn(string tag, int op, int arg, int sf, int len);
        idle();
        op_valid_i = 1; op_i = 3'(op); arg_i = 13'(arg); sf_i = sf[0]; len_i = 2'(len);
        tick(tag);
    endtask

    initial begin
        // R1: reset state
        rst = 1; tick("R1"); tick("R1");
        // R4: sequential by length
        insn("R4", 0, 0, 0, 1); insn("R4", 0, 0, 0, 2); insn("R4", 0, 0, 0, 3);
        insn("R4", 7, 0, 0, 2);
        // R13: idle hold
        idle(); tick("R13"); tick("R13");
        // R5: short branch taken / not taken
        insn("R5", 1, 13'h1FD5, 1, 1); insn("R5", 1, 13'h0003, 0, 1);
        // R7: full branch into the upper window, R2 map with code 00
        insn("R7", 3, 13'h1234, 1, 1); insn("R7", 3, 13'h0000, 0, 1);
        // R3: bank codes 01, 10, 11 while stepping
        idle(); op_valid_i = 1; op_i = 0; len_i = 1; bank_we_i = 1; bank_d_i = 2'b01; tick("R3");
        idle(); tick("R2");
        bank_we_i = 1; bank_d_i = 2'b10; tick("R3");
        idle(); tick("R2");
        bank_we_i = 1; bank_d_i = 2'b11; tick("R3");
        idle(); tick("R2");
        // R6: long branch keeps bit 12
        insn("R6", 2, 13'h0ABC, 1, 1); insn("R6", 2, 13'h0123, 0, 1);
        // R8: short call indices
        insn("R8", 4, 0, 0, 1); insn("R8", 4, 1, 0, 1); insn("R8", 4, 15, 0, 1);
        // R9: long call from the upper window
        insn("R7", 3, 13'h1F00, 1, 1);
        insn("R9", 5, 13'h1FFF, 0, 1);
        // R10: each interrupt source, then a collision
        for (int i = 0; i < 6; i++) begin
            insn("R4", 0, 0, 0, 3);
            idle(); irq_i = 6'(1 << i); tick("R10");
        end
        idle(); irq_i = 6'b101000; tick("R10");
        idle(); irq_i = 6'b110010; tick("R10");
        // R11: return and return from interrupt
        idle(); ret_i = 1; ret_data_i = 13'h1555; tick("R11");
        idle(); rti_i = 1; ret_data_i = 13'h0ACE; tick("R11");
        idle(); tick("R11");
        // R12: priority collisions
        idle(); irq_i = 6'b000100; rti_i = 1; ret_data_i = 13'h1111;
        op_valid_i = 1; op_i = 4; arg_i = 5; tick("R12");
        idle(); ret_i = 1; ret_data_i = 13'h0777; op_valid_i = 1; op_i = 5; arg_i = 13'h0123; tick("R12");
        idle(); rti_i = 1; ret_data_i = 13'h0042; op_valid_i = 1; op_i = 3; sf_i = 1; arg_i = 13'h1FFF; tick("R12");
        idle(); bank_we_i = 1; bank_d_i = 2'b10; tick("R3");
        idle(); rst = 1; irq_i = 6'b000001; ret_i = 1; bank_we_i = 1; bank_d_i = 2'b01; tick("R12");
        idle(); tick("R1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule